// File: doc/BRIEF.md
# Burst Read Handshake FIFO Port

A synchronous FIFO whose consumer side is built for a request/acknowledge protocol. Every stored entry pairs a data word with a tag field. The consumer raises a one-cycle request. The block answers one clock later with the acknowledge, the data and the tag, because the storage array is read through a register. If the burst input is low during the request cycle, exactly one word moves. If it is high, the block keeps acknowledging on back-to-back cycles until `BURST_LEN` words have moved or the FIFO runs dry, whichever comes first.

Three discrete status outputs tell the consumer when a transfer is worthwhile: occupancy, empty and almost-empty. They come straight from the occupancy register and are refreshed at the end of every acknowledged beat. A minimal write port, with a full indication, fills the store. `DEPTH` may be any value of 2 or more.

Top module: `burst_rd_fifo`

## Requirements
- R1: Each acknowledged beat returns the data word and the tag that were written together, in write order.
- R2: For a request sampled in cycle N, `rd_ack_o`, `rd_data_o` and `rd_tag_o` are valid in cycle N+1.
- R3: A request with `rd_burst_i` low moves exactly one word; `rd_ack_o` is low in the following cycle.
- R4: A request with `rd_burst_i` high gives `BURST_LEN` acknowledges on consecutive cycles when enough words are held; `rd_ack_o` then falls.
- R5: `count_o` drops by one at the end of each acknowledged cycle and rises by one at the end of each accepted write cycle.
- R6: `aempty_o` is high exactly when `count_o` equals 1.
- R7: `empty_o` is high exactly when `count_o` equals 0.
- R8: A request made while no unread word is available is dropped and is never acknowledged later.
- R9: An accepted write in the same cycle as an acknowledge leaves `count_o` unchanged.
- R10: A burst that drains the FIFO before `BURST_LEN` beats ends at once; `rd_ack_o` falls after the last word.
- R11: `full_o` is high when `count_o` equals `DEPTH`; a write attempted while full is discarded.
- R12: After reset, `count_o` is 0, `empty_o` is 1, and `aempty_o`, `full_o` and `rd_ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data word |
| wr_tag_i | input | TAG_W | Write tag field |
| full_o | output | 1 | FIFO holds DEPTH words |
| rd_req_i | input | 1 | Read request, one-cycle pulse |
| rd_burst_i | input | 1 | High: burst transfer; low: single beat |
| rd_ack_o | output | 1 | Beat valid on rd_data_o / rd_tag_o |
| rd_data_o | output | DATA_W | Read data word |
| rd_tag_o | output | TAG_W | Read tag field |
| count_o | output | $clog2(DEPTH+1) | Occupied entries |
| empty_o | output | 1 | Occupancy is zero |
| aempty_o | output | 1 | Occupancy is one |

## Verification
The hardest case to reach is the overlap of a beat already in flight with a new event. One variant is a write that lands in the same cycle as an acknowledge. The other is a burst that runs out of words partway through. Both depend on the one-cycle gap between issuing a read and counting it. The bench reaches the first by raising the write strobe in the exact acknowledge cycle of a single-beat read. It reaches the second by asking for a full burst while fewer words are held, then draining a full FIFO with back-to-back bursts and checking the occupancy on every beat.

// File: rtl/burst_rd_fifo_pkg.sv
`timescale 1ns/1ps
package burst_rd_fifo_pkg;
  typedef enum logic [0:0] {
    RD_IDLE  = 1'b0,
    RD_BURST = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/bfifo_store.sv
`timescale 1ns/1ps
module bfifo_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o
);
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } entry_t;

  entry_t mem_q [DEPTH];
  entry_t rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= '{tag: wr_tag_i, data: wr_data_i};
  end

  // registered read: one cycle from issue to data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q.data;
  assign rd_tag_o  = rd_q.tag;
endmodule

// File: rtl/bfifo_occ.sv
`timescale 1ns/1ps
module bfifo_occ #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          issue_i,
  input  logic          ack_i,
  output logic          wr_fire_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          avail_nz_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          aempty_o
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] unread;

  assign full_o    = (count_q == CNT_FULL);
  assign wr_fire_o = wr_req_i && !full_o;
  // count still includes the beat in flight; it is not issuable again
  assign unread     = count_q - CW'(ack_i);
  assign avail_nz_o = (unread != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_fire_o) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (issue_i)   rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_fire_o, ack_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;
  assign empty_o  = (count_q == '0);
  assign aempty_o = (count_q == CW'(1));

  AST_NO_ACK_WHEN_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> count_q != '0); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && aempty_o)); // R6
  AST_SIMUL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_o && ack_i) |=> $stable(count_q)); // R9
  AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !ack_i) |=> full_o); // R11
endmodule

// File: rtl/bfifo_rd_ctrl.sv
`timescale 1ns/1ps
module bfifo_rd_ctrl
  import burst_rd_fifo_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned LW       = $clog2(BURST_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic rd_burst_i,
  input  logic avail_nz_i,
  output logic issue_o,
  output logic ack_o
);
  logic ack_q;

  generate
    if (BURST_LEN > 1) begin : g_burst
      rd_mode_e      mode_q;
      logic [LW-1:0] left_q;

      assign issue_o = avail_nz_i && ((mode_q == RD_BURST) || rd_req_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mode_q <= RD_IDLE;
          left_q <= '0;
        end else if (mode_q == RD_IDLE) begin
          if (issue_o && rd_burst_i) begin
            mode_q <= RD_BURST;
            left_q <= LW'(BURST_LEN - 1);
          end
        end else if (!avail_nz_i) begin
          mode_q <= RD_IDLE;          // ran dry: end burst early
          left_q <= '0;
        end else begin
          left_q <= left_q - 1'b1;
          if (left_q == LW'(1)) mode_q <= RD_IDLE;
        end
      end

      AST_SINGLE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == RD_IDLE && !rd_burst_i) |=> mode_q == RD_IDLE); // R3
      AST_BURST_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == RD_BURST) |-> (left_q != '0 && left_q < LW'(BURST_LEN))); // R4
    end else begin : g_single
      assign issue_o = avail_nz_i && rd_req_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= issue_o;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/burst_rd_fifo.sv
`timescale 1ns/1ps
module burst_rd_fifo #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_W     = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  output logic              full_o,
  input  logic              rd_req_i,
  input  logic              rd_burst_i,
  output logic              rd_ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              aempty_o
);
  logic          wr_fire, issue, avail_nz;
  logic [AW-1:0] wr_ptr, rd_ptr;

  bfifo_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_en_i),
    .issue_i    (issue),
    .ack_i      (rd_ack_o),
    .wr_fire_o  (wr_fire),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .avail_nz_o (avail_nz),
    .count_o    (count_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .aempty_o   (aempty_o)
  );

  bfifo_rd_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (rd_req_i),
    .rd_burst_i (rd_burst_i),
    .avail_nz_i (avail_nz),
    .issue_o    (issue),
    .ack_o      (rd_ack_o)
  );

  bfifo_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_fire),
    .wr_addr_i (wr_ptr),
    .wr_data_i (wr_data_i),
    .wr_tag_i  (wr_tag_i),
    .rd_en_i   (issue),
    .rd_addr_i (rd_ptr),
    .rd_data_o (rd_data_o),
    .rd_tag_o  (rd_tag_o)
  );

  AST_NO_ISSUE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> !empty_o); // R8
  AST_ACK_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> $past(count_o) != '0); // R2
endmodule

// File: tb/tb_burst_rd_fifo.sv
`timescale 1ns/1ps
module tb_burst_rd_fifo;
  localparam int DATA_W = 32, TAG_W = 4, DEPTH = 16, BURST_LEN = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_req = 1'b0, rd_burst = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [TAG_W-1:0]  wr_tag = '0;
  logic full, ack, empty, aempty;
  logic [DATA_W-1:0] rd_data;
  logic [TAG_W-1:0]  rd_tag;
  logic [CW-1:0]     count;

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] exp_d [64];
  logic [TAG_W-1:0]  exp_t [64];
  int head = 0, tail = 0, seq = 0;

  always #10 clk = ~clk; // 50 MHz

  burst_rd_fifo #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_tag_i(wr_tag),
    .full_o(full), .rd_req_i(rd_req), .rd_burst_i(rd_burst), .rd_ack_o(ack),
    .rd_data_o(rd_data), .rd_tag_o(rd_tag), .count_o(count), .empty_o(empty), .aempty_o(aempty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // drive one word; all tasks start and end on a falling edge
  task automatic set_word(input bit push);
    wr_data = 32'h5A00_0000 + 32'(seq * 7);
    wr_tag  = TAG_W'(seq);
    if (push) begin exp_d[tail] = wr_data; exp_t[tail] = wr_tag; tail++; end
    seq++;
  endtask

  task automatic write_word(input bit accept);
    wr_en = 1'b1;
    set_word(accept);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) write_word(1'b1);
    chk("R5 count after writes", 64'(count), 64'(tail - head));
  endtask

  task automatic beat();
    chk("R2 ack", 64'(ack), 64'd1);
    chk("R1 data", 64'(rd_data), 64'(exp_d[head]));
    chk("R1 tag", 64'(rd_tag), 64'(exp_t[head]));
    head++;
  endtask

  task automatic t_reset();
    chk("R12 count", 64'(count), 64'd0);
    chk("R12 empty", 64'(empty), 64'd1);
    chk("R12 aempty", 64'(aempty), 64'd0);
    chk("R12 full", 64'(full), 64'd0);
    chk("R12 ack", 64'(ack), 64'd0);
  endtask

  task automatic t_empty_req();
    rd_req = 1'b1; rd_burst = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R8 no ack while empty", 64'(ack), 64'd0);
      @(negedge clk);
    end
    write_word(1'b1);
    chk("R8 request not retained", 64'(ack), 64'd0);
    @(negedge clk);
    chk("R8 request not retained", 64'(ack), 64'd0);
    chk("R6 aempty at one", 64'(aempty), 64'd1);
  endtask

  task automatic t_single();
    rd_req = 1'b1; rd_burst = 1'b0;
    @(negedge clk);
    rd_req = 1'b0;
    beat();
    chk("R5 count before ack edge", 64'(count), 64'd5);
    @(negedge clk);
    chk("R3 single beat ends", 64'(ack), 64'd0);
    chk("R5 count after single", 64'(count), 64'd4);
  endtask

  task automatic t_burst();
    rd_req = 1'b1; rd_burst = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < BURST_LEN; k++) begin
      beat();
      chk("R5 count per beat", 64'(count), 64'(4 - k));
      chk("R6 aempty per beat", 64'(aempty), 64'((4 - k) == 1));
      @(negedge clk);
    end
    chk("R4 ack drops after burst", 64'(ack), 64'd0);
    chk("R7 empty", 64'(empty), 64'd1);
    chk("R7 count zero", 64'(count), 64'd0);
  endtask

  task automatic t_early();
    fill(2);
    rd_req = 1'b1; rd_burst = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < 2; k++) begin beat(); @(negedge clk); end
    chk("R10 early end ack", 64'(ack), 64'd0);
    chk("R10 empty after early end", 64'(empty), 64'd1);
    @(negedge clk);
    chk("R10 stays idle", 64'(ack), 64'd0);
  endtask

  task automatic t_simul();
    fill(3);
    rd_req = 1'b1; rd_burst = 1'b0;
    @(negedge clk);
    rd_req = 1'b0;
    beat();
    wr_en = 1'b1;
    set_word(1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 count unchanged", 64'(count), 64'd3);
    rd_req = 1'b1; rd_burst = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < 3; k++) begin beat(); @(negedge clk); end
    chk("R10 ack drops at drain", 64'(ack), 64'd0);
    chk("R7 empty after drain", 64'(empty), 64'd1);
  endtask

  task automatic t_full();
    fill(DEPTH);
    chk("R11 full", 64'(full), 64'd1);
    write_word(1'b0);
    chk("R11 write discarded", 64'(count), 64'(DEPTH));
    for (int b = 0; b < DEPTH / BURST_LEN; b++) begin
      rd_req = 1'b1; rd_burst = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      for (int k = 0; k < BURST_LEN; k++) begin beat(); @(negedge clk); end
      chk("R4 ack drops", 64'(ack), 64'd0);
      chk("R5 count after burst", 64'(count), 64'(DEPTH - (b + 1) * BURST_LEN));
    end
    chk("R7 empty after full drain", 64'(empty), 64'd1);
    chk("R11 not full", 64'(full), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_req();
    fill(4);
    t_single();
    t_burst();
    t_early();
    t_simul();
    t_full();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end
endmodule